// File: doc/BRIEF.md
# Serial Divider-Setting Loader for a Dual Synthesizer

This block takes the three-wire programming port of a dual (IF and RF) frequency synthesizer and turns it into the divider settings and option bits that the rest of the synthesizer uses. The port has a serial clock, a serial data line and a load strobe. All three pins are asynchronous to the system clock. The block synchronizes them and shifts one data bit into a 23-bit register on each rising edge of the serial clock. On each rising edge of the load strobe, it copies the captured word into one of four setting latches.

The two bits shifted in last form a latch code. The code picks the IF reference, IF program, RF reference or RF program latch. A reference word carries a 14-bit divide value and a polarity-reverse bit. The IF reference word also carries the monitor-select bit. A program word carries a 7-bit swallow count and an 11-bit main count. The RF program word also carries the prescaler-select bit.

A word whose divide value (reference) or main count (program) is below the legal minimum is refused. A refused word leaves every latch as it was and raises an error flag. The block also applies the option bits in two places. It steers the shared monitor output, and it swaps the up and down pump requests of each loop whose polarity bit is set. The serial port is a plain pin protocol: a word is consumed only at a load edge, and there is no valid/ready handshake and no back-pressure.

Top module: `pll_ser_loader`

## Requirements
- R1: The shift register keeps the last 23 bits clocked in on rising edges of `ser_clk`, with the most significant bit first. Bits shifted in before those 23 have no effect on what is loaded.
- R2: Latch contents change only in response to a rising edge of `ser_le`. Shifting while `ser_le` stays low leaves every setting output unchanged.
- R3: Latch code 00 (word bits [1:0]) loads the IF reference latch. The divide value comes from bits [15:2], the IF polarity bit from bit 21 and the monitor-select bit from bit 22. No other latch changes.
- R4: Latch code 01 loads the IF program latch. The swallow count comes from bits [8:2] and the main count from bits [19:9]. Bit 20 is ignored and no other latch changes.
- R5: Latch code 10 loads the RF reference latch. The divide value comes from bits [15:2] and the RF polarity bit from bit 21. Bit 22 is ignored for this code, and no other latch changes.
- R6: Latch code 11 loads the RF program latch. The swallow count comes from bits [8:2], the main count from bits [19:9] and the prescaler select from bit 20.
- R7: A reference word with a divide value below 5, or a program word with a main count below 5, is refused. All latches keep their contents and `load_err` goes to 1. An accepted load sets `load_err` to 0. The values 5 and 16383 are accepted.
- R8: `mon_out` follows `phase_mon` when the monitor-select bit is 1 and follows `lock_det` when it is 0.
- R9: When a loop's polarity bit is 1, its pump outputs carry that loop's swapped requests: up = dn-request and dn = up-request. When the bit is 0, the requests pass through unchanged.
- R10: After reset, both divide values and both main counts are 5, both swallow counts are 0, all option bits are 0 and `load_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first (asynchronous) |
| ser_le | input | 1 | Load strobe; its rising edge commits the word |
| lock_det | input | 1 | Lock-detect indication to route |
| phase_mon | input | 1 | Phase-comparator monitor signal to route |
| if_pd_up | input | 1 | IF phase-detector up request |
| if_pd_dn | input | 1 | IF phase-detector down request |
| rf_pd_up | input | 1 | RF phase-detector up request |
| rf_pd_dn | input | 1 | RF phase-detector down request |
| mon_out | output | 1 | Shared monitor output |
| if_cp_up | output | 1 | IF pump up after polarity |
| if_cp_dn | output | 1 | IF pump down after polarity |
| rf_cp_up | output | 1 | RF pump up after polarity |
| rf_cp_dn | output | 1 | RF pump down after polarity |
| if_ref_div | output | 14 | IF reference divide value |
| if_swallow | output | 7 | IF swallow count |
| if_main | output | 11 | IF main count |
| rf_ref_div | output | 14 | RF reference divide value |
| rf_swallow | output | 7 | RF swallow count |
| rf_main | output | 11 | RF main count |
| rf_presc_sel | output | 1 | RF prescaler select |
| load_err | output | 1 | Last load was refused |

## Verification
Words are sent with each of the four latch codes, using field values that differ between latches. A field that lands in the wrong latch, or a wrong bit slice, therefore shows up as a mismatch in the full snapshot of all settings. Words are also sent with out-of-range values in the bits that each code must ignore. Two boundary groups cover the R7 rule: the values 4 (refused) and 5 and 16383 (accepted) separate the refusal threshold from an off-by-one. A word sent with no load edge, and a word preceded by extra leading bits, separate a correct commit point and register length from a design that loads while shifting or keeps too many bits. The monitor and pump outputs are driven with opposite input patterns under both settings of each option bit.

// File: rtl/pll_ser_pkg.sv
package pll_ser_pkg;
  localparam int WORD_W    = 23;
  localparam int REF_W     = 14;
  localparam int SW_W      = 7;
  localparam int MAIN_W    = 11;
  localparam int SEL_LSB   = 0;
  localparam int FIELD_LSB = 2;
  localparam int MAIN_LSB  = FIELD_LSB + SW_W;
  localparam int PRESC_BIT = MAIN_LSB + MAIN_W;
  localparam int FC_BIT    = PRESC_BIT + 1;
  localparam int LDS_BIT   = FC_BIT + 1;

  typedef enum logic [1:0] {
    SEL_IF_REF = 2'b00,
    SEL_IF_PRG = 2'b01,
    SEL_RF_REF = 2'b10,
    SEL_RF_PRG = 2'b11
  } latch_sel_e;

  typedef struct packed {
    logic [REF_W-1:0]  if_ref_div;
    logic [SW_W-1:0]   if_swallow;
    logic [MAIN_W-1:0] if_main;
    logic [REF_W-1:0]  rf_ref_div;
    logic [SW_W-1:0]   rf_swallow;
    logic [MAIN_W-1:0] rf_main;
    logic              if_fc;
    logic              rf_fc;
    logic              lds;
    logic              rf_presc;
  } cfg_t;
endpackage

// File: rtl/pll_ser_sync.sv
module pll_ser_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/pll_ser_shift.sv
module pll_ser_shift #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         data_s,
  output logic [W-1:0] word
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      word   <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (sclk_s && !sclk_q) word <= {word[W-2:0], data_s};
    end
  end
endmodule

// File: rtl/pll_ser_regs.sv
module pll_ser_regs
  import pll_ser_pkg::*;
#(
  parameter int MIN_DIV = 5,
  parameter int RST_DIV = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              le_s,
  input  logic [WORD_W-1:0] word,
  output cfg_t              cfg,
  output logic              load_err,
  output logic              load_stb
);
  localparam logic [REF_W-1:0]  MIN_REF  = REF_W'(MIN_DIV);
  localparam logic [MAIN_W-1:0] MIN_MAIN = MAIN_W'(MIN_DIV);

  logic              le_q;
  latch_sel_e        sel;
  logic [REF_W-1:0]  div_f;
  logic [SW_W-1:0]   sw_f;
  logic [MAIN_W-1:0] main_f;
  cfg_t              nxt;
  logic              ok;

  assign load_stb = le_s & ~le_q;
  assign sel      = latch_sel_e'(word[SEL_LSB +: 2]);
  assign div_f    = word[FIELD_LSB +: REF_W];
  assign sw_f     = word[FIELD_LSB +: SW_W];
  assign main_f   = word[MAIN_LSB +: MAIN_W];

  always_comb begin
    nxt = cfg;
    ok  = 1'b1;
    unique case (sel)
      SEL_IF_REF: begin
        if (div_f < MIN_REF) ok = 1'b0;
        else begin
          nxt.if_ref_div = div_f;
          nxt.if_fc      = word[FC_BIT];
          nxt.lds        = word[LDS_BIT];
        end
      end
      SEL_RF_REF: begin
        if (div_f < MIN_REF) ok = 1'b0;
        else begin
          nxt.rf_ref_div = div_f;
          nxt.rf_fc      = word[FC_BIT];
        end
      end
      SEL_IF_PRG: begin
        if (main_f < MIN_MAIN) ok = 1'b0;
        else begin
          nxt.if_swallow = sw_f;
          nxt.if_main    = main_f;
        end
      end
      SEL_RF_PRG: begin
        if (main_f < MIN_MAIN) ok = 1'b0;
        else begin
          nxt.rf_swallow = sw_f;
          nxt.rf_main    = main_f;
          nxt.rf_presc   = word[PRESC_BIT];
        end
      end
      default: ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_q           <= 1'b0;
      load_err       <= 1'b0;
      cfg.if_ref_div <= REF_W'(RST_DIV);
      cfg.rf_ref_div <= REF_W'(RST_DIV);
      cfg.if_main    <= MAIN_W'(RST_DIV);
      cfg.rf_main    <= MAIN_W'(RST_DIV);
      cfg.if_swallow <= '0;
      cfg.rf_swallow <= '0;
      cfg.if_fc      <= 1'b0;
      cfg.rf_fc      <= 1'b0;
      cfg.lds        <= 1'b0;
      cfg.rf_presc   <= 1'b0;
    end else begin
      le_q <= le_s;
      if (load_stb) begin
        if (ok) cfg <= nxt;
        load_err <= ~ok;
      end
    end
  end
endmodule

// File: rtl/pll_ser_outmux.sv
module pll_ser_outmux #(
  parameter int LOOPS = 2
) (
  input  logic             lds,
  input  logic             lock_det,
  input  logic             phase_mon,
  input  logic [LOOPS-1:0] fc,
  input  logic [LOOPS-1:0] pd_up,
  input  logic [LOOPS-1:0] pd_dn,
  output logic             mon_out,
  output logic [LOOPS-1:0] cp_up,
  output logic [LOOPS-1:0] cp_dn
);
  assign mon_out = lds ? phase_mon : lock_det;

  for (genvar g = 0; g < LOOPS; g++) begin : g_loop
    assign cp_up[g] = fc[g] ? pd_dn[g] : pd_up[g];
    assign cp_dn[g] = fc[g] ? pd_up[g] : pd_dn[g];
  end
endmodule

// File: rtl/pll_ser_loader.sv
module pll_ser_loader
  import pll_ser_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_DIV     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  input  logic              lock_det,
  input  logic              phase_mon,
  input  logic              if_pd_up,
  input  logic              if_pd_dn,
  input  logic              rf_pd_up,
  input  logic              rf_pd_dn,
  output logic              mon_out,
  output logic              if_cp_up,
  output logic              if_cp_dn,
  output logic              rf_cp_up,
  output logic              rf_cp_dn,
  output logic [REF_W-1:0]  if_ref_div,
  output logic [SW_W-1:0]   if_swallow,
  output logic [MAIN_W-1:0] if_main,
  output logic [REF_W-1:0]  rf_ref_div,
  output logic [SW_W-1:0]   rf_swallow,
  output logic [MAIN_W-1:0] rf_main,
  output logic              rf_presc_sel,
  output logic              load_err
);
  localparam int LOOPS = 2;

  logic [2:0]        pins_s;
  logic [WORD_W-1:0] word;
  cfg_t              cfg;
  logic              le_rise;
  logic [LOOPS-1:0]  cp_up;
  logic [LOOPS-1:0]  cp_dn;

  pll_ser_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ser_le, ser_data, ser_clk}),
    .dout (pins_s)
  );

  pll_ser_shift #(.W(WORD_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk_s(pins_s[0]),
    .data_s(pins_s[1]),
    .word  (word)
  );

  pll_ser_regs #(.MIN_DIV(MIN_DIV), .RST_DIV(MIN_DIV)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .le_s    (pins_s[2]),
    .word    (word),
    .cfg     (cfg),
    .load_err(load_err),
    .load_stb(le_rise)
  );

  pll_ser_outmux #(.LOOPS(LOOPS)) u_mux (
    .lds      (cfg.lds),
    .lock_det (lock_det),
    .phase_mon(phase_mon),
    .fc       ({cfg.rf_fc, cfg.if_fc}),
    .pd_up    ({rf_pd_up, if_pd_up}),
    .pd_dn    ({rf_pd_dn, if_pd_dn}),
    .mon_out  (mon_out),
    .cp_up    (cp_up),
    .cp_dn    (cp_dn)
  );

  assign if_cp_up     = cp_up[0];
  assign if_cp_dn     = cp_dn[0];
  assign rf_cp_up     = cp_up[1];
  assign rf_cp_dn     = cp_dn[1];
  assign if_ref_div   = cfg.if_ref_div;
  assign if_swallow   = cfg.if_swallow;
  assign if_main      = cfg.if_main;
  assign rf_ref_div   = cfg.rf_ref_div;
  assign rf_swallow   = cfg.rf_swallow;
  assign rf_main      = cfg.rf_main;
  assign rf_presc_sel = cfg.rf_presc;
endmodule

// File: rtl/pll_ser_chk.sv
module pll_ser_chk
  import pll_ser_pkg::*;
#(
  parameter int MIN_DIV = 5
) (
  input logic clk,
  input logic rst_n,
  input logic le_rise,
  input cfg_t cfg,
  input logic load_err,
  input logic lock_det,
  input logic phase_mon,
  input logic mon_out,
  input logic if_pd_up,
  input logic if_pd_dn,
  input logic rf_pd_up,
  input logic rf_pd_dn,
  input logic if_cp_up,
  input logic if_cp_dn,
  input logic rf_cp_up,
  input logic rf_cp_dn
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(cfg));

  p_err_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_err) |-> $past(le_rise));

  p_min_div_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cfg.if_ref_div) >= MIN_DIV) && (32'(cfg.rf_ref_div) >= MIN_DIV) &&
    (32'(cfg.if_main) >= MIN_DIV) && (32'(cfg.rf_main) >= MIN_DIV));

  p_mon_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.lds |-> (mon_out == phase_mon));

  p_mon_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.lds |-> (mon_out == lock_det));

  p_if_pol_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.if_fc |-> (if_cp_up == if_pd_dn && if_cp_dn == if_pd_up));

  p_rf_pol_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.rf_fc |-> (rf_cp_up == rf_pd_dn && rf_cp_dn == rf_pd_up));

  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.if_fc && !cfg.rf_fc) |->
      (if_cp_up == if_pd_up && rf_cp_dn == rf_pd_dn &&
       if_cp_dn == if_pd_dn && rf_cp_up == rf_pd_up));
endmodule

bind pll_ser_loader pll_ser_chk #(.MIN_DIV(MIN_DIV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .le_rise  (le_rise),
  .cfg      (cfg),
  .load_err (load_err),
  .lock_det (lock_det),
  .phase_mon(phase_mon),
  .mon_out  (mon_out),
  .if_pd_up (if_pd_up),
  .if_pd_dn (if_pd_dn),
  .rf_pd_up (rf_pd_up),
  .rf_pd_dn (rf_pd_dn),
  .if_cp_up (if_cp_up),
  .if_cp_dn (if_cp_dn),
  .rf_cp_up (rf_cp_up),
  .rf_cp_dn (rf_cp_dn)
);

// File: tb/test_pll_ser_loader.sv
`timescale 1ns/1ps
module test_pll_ser_loader;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic ser_clk = 0, ser_data = 0, ser_le = 0;
  logic lock_det = 0, phase_mon = 0;
  logic if_pd_up = 0, if_pd_dn = 0, rf_pd_up = 0, rf_pd_dn = 0;
  logic mon_out, if_cp_up, if_cp_dn, rf_cp_up, rf_cp_dn;
  logic [13:0] if_ref_div, rf_ref_div;
  logic [6:0]  if_swallow, rf_swallow;
  logic [10:0] if_main, rf_main;
  logic rf_presc_sel, load_err;

  pll_ser_loader i_pll_ser_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .lock_det(lock_det), .phase_mon(phase_mon),
    .if_pd_up(if_pd_up), .if_pd_dn(if_pd_dn), .rf_pd_up(rf_pd_up),
    .rf_pd_dn(rf_pd_dn), .mon_out(mon_out), .if_cp_up(if_cp_up),
    .if_cp_dn(if_cp_dn), .rf_cp_up(rf_cp_up), .rf_cp_dn(rf_cp_dn),
    .if_ref_div(if_ref_div), .if_swallow(if_swallow), .if_main(if_main),
    .rf_ref_div(rf_ref_div), .rf_swallow(rf_swallow), .rf_main(rf_main),
    .rf_presc_sel(rf_presc_sel), .load_err(load_err)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [65:0] exp_q[$];
  string tag_q[$];
  event chk_ev;

  // reference model of the settings, built from the requirements
  logic [13:0] m_if_ref = 14'd5, m_rf_ref = 14'd5;
  logic [6:0]  m_if_sw = '0, m_rf_sw = '0;
  logic [10:0] m_if_main = 11'd5, m_rf_main = 11'd5;
  logic m_presc = 0, m_err = 0, m_if_fc = 0, m_rf_fc = 0, m_lds = 0;

  function automatic logic [65:0] model_snap();
    return {m_if_ref, m_if_sw, m_if_main, m_rf_ref, m_rf_sw, m_rf_main, m_presc, m_err};
  endfunction

  function automatic logic [65:0] dut_snap();
    return {if_ref_div, if_swallow, if_main, rf_ref_div, rf_swallow, rf_main,
            rf_presc_sel, load_err};
  endfunction

  function automatic logic [22:0] ref_word(logic [1:0] code, logic [13:0] dv,
                                           logic fc, logic lds);
    logic [22:0] w = '0;
    w[1:0] = code; w[15:2] = dv; w[21] = fc; w[22] = lds;
    return w;
  endfunction

  function automatic logic [22:0] prg_word(logic [1:0] code, logic [6:0] sw,
                                           logic [10:0] mn, logic ps);
    logic [22:0] w = '0;
    w[1:0] = code; w[8:2] = sw; w[19:9] = mn; w[20] = ps;
    return w;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [65:0] act, logic [65:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected snapshots and compares with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) check(tag_q.pop_front(), dut_snap(), exp_q.pop_front());
    end
  end

  task automatic expect_snap(string tag);
    exp_q.push_back(model_snap());
    tag_q.push_back(tag);
    ->chk_ev;
    tick(1);
  endtask

  task automatic shift_bits(logic [24:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i];
      tick(4);
      ser_clk = 1'b1;
      tick(4);
      ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_le();
    ser_le = 1'b1;
    tick(6);
    ser_le = 1'b0;
    tick(4);
  endtask

  task automatic model_apply(logic [22:0] w);
    case (w[1:0])
      2'b00: if (w[15:2] < 14'd5) m_err = 1;
             else begin m_if_ref = w[15:2]; m_if_fc = w[21]; m_lds = w[22]; m_err = 0; end
      2'b10: if (w[15:2] < 14'd5) m_err = 1;
             else begin m_rf_ref = w[15:2]; m_rf_fc = w[21]; m_err = 0; end
      2'b01: if (w[19:9] < 11'd5) m_err = 1;
             else begin m_if_sw = w[8:2]; m_if_main = w[19:9]; m_err = 0; end
      default: if (w[19:9] < 11'd5) m_err = 1;
             else begin m_rf_sw = w[8:2]; m_rf_main = w[19:9]; m_presc = w[20]; m_err = 0; end
    endcase
  endtask

  task automatic send(logic [22:0] w, string tag);
    shift_bits({2'b00, w}, 23);
    pulse_le();
    model_apply(w);
    expect_snap(tag);
  endtask

  task automatic check_pins(string tag);
    for (int p = 0; p < 2; p++) begin
      lock_det = (p == 0); phase_mon = (p != 0);
      if_pd_up = (p == 0); if_pd_dn = (p != 0);
      rf_pd_up = (p != 0); rf_pd_dn = (p == 0);
      tick(1);
      check({tag, " R8 mon"}, 66'(mon_out), 66'(m_lds ? phase_mon : lock_det));
      check({tag, " R9 if"}, 66'({if_cp_up, if_cp_dn}),
            66'(m_if_fc ? {if_pd_dn, if_pd_up} : {if_pd_up, if_pd_dn}));
      check({tag, " R9 rf"}, 66'({rf_cp_up, rf_cp_dn}),
            66'(m_rf_fc ? {rf_pd_dn, rf_pd_up} : {rf_pd_up, rf_pd_dn}));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    expect_snap("R10 reset state");
    check_pins("R10 reset options");

    send(ref_word(2'b00, 14'd1000, 1'b1, 1'b1), "R3 IF ref load");
    check_pins("R3 IF options");
    send(prg_word(2'b01, 7'd33, 11'd700, 1'b1), "R4 IF prog load, bit20 ignored");
    send(ref_word(2'b10, 14'd16383, 1'b1, 1'b0), "R5 RF ref max value");
    check_pins("R5 RF polarity");
    send(ref_word(2'b10, 14'd321, 1'b0, 1'b1), "R5 RF ref, bit22 ignored");
    check_pins("R5 lds untouched");
    send(prg_word(2'b11, 7'd127, 11'd2047, 1'b1), "R6 RF prog load");
    send(prg_word(2'b11, 7'd9, 11'd77, 1'b0), "R6 RF prog presc clear");

    send(ref_word(2'b00, 14'd4, 1'b0, 1'b0), "R7 IF ref 4 refused");
    check_pins("R7 options kept");
    send(prg_word(2'b11, 7'd1, 11'd4, 1'b1), "R7 RF main 4 refused");
    send(ref_word(2'b00, 14'd5, 1'b0, 1'b0), "R7 IF ref 5 accepted");
    check_pins("R8 lock routed");
    send(prg_word(2'b01, 7'd0, 11'd3, 1'b0), "R7 IF main 3 refused");
    send(prg_word(2'b01, 7'd64, 11'd5, 1'b0), "R7 IF main 5 accepted");

    shift_bits({2'b00, ref_word(2'b10, 14'd999, 1'b1, 1'b0)}, 23);
    tick(4);
    expect_snap("R2 shift without load edge");

    begin
      logic [22:0] w = prg_word(2'b11, 7'd55, 11'd1234, 1'b1);
      shift_bits({2'b11, w}, 25);
      pulse_le();
      model_apply(w);
      expect_snap("R1 extra leading bits dropped");
    end

    tick(5);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule